// File: doc/BRIEF.md
# Saturating Fractional Result Read Path

This block sits between the result registers of a signed multiply-accumulate unit and the bus read port. The stored result is never rewritten. Only the copy handed to a reader is adjusted, so software can turn clamping on to read a clamped value and turn it off to read the raw one, without any change to storage.

When clamping is on, a result that has grown past the signed range is replaced by the most positive value, and one that has fallen below it by the most negative value. The decision rests on the carry bit and the most significant bit of the active field. For 16x16 operations the active field is the low two 16-bit words and the upper words pass through unchanged. For every wider operation the whole four-word result is the active field. In fractional format a read returns the result shifted left by one bit. With clamping on, a result whose top two bits differ before the shift is clamped by its sign. The value fed back as the next accumulation addend is clamped with integer rules only and is never shifted. This keeps extra headroom during accumulation and leaves fractional clamping to the final read.

All outputs are registered, so they reflect the inputs of the previous clock.

Top module: `fsat_read_path`

## Requirements
- R1: With clamping and fractional format both off, the read data equals the raw result one cycle later.
- R2: With clamping on in 16x16 mode, raw bit 31 = 1 with carry = 0 makes read words 0 and 1 return 7FFF_FFFFh.
- R3: With clamping on in 16x16 mode, raw bit 31 = 0 with carry = 1 makes read words 0 and 1 return 8000_0000h.
- R4: In 16x16 mode (op_wide_i = 0), read words 2 and 3 always equal the raw upper 32 bits.
- R5: In wide mode (op_wide_i = 1), clamping is judged on bit 63 and the carry, and it covers all 64 bits: 7FFF..FFh on overflow, 8000..00h on underflow.
- R6: With fractional format on and no clamping condition met, the active field reads back as the raw field shifted left by one bit, with a 0 shifted in. This holds whether clamping is on or off.
- R7: With clamping and fractional format on, no integer clamp, and the top two raw bits of the active field differing, the read clamps by the raw sign bit. A raw value of 4000_0000h (-1.0 x -1.0) reads 7FFF_FFFFh.
- R8: The accumulation addend equals the raw result when clamping is off. When clamping is on it follows the integer rules of R2, R3 and R5 and ignores the fractional setting.
- R9: With 8000_059Fh in the low words, zeros above, carry 0, and clamping and fractional format on in 16x16 mode, word 0 reads FFFFh and word 1 reads 7FFFh.
- R10: rd_valid_o is low while wide mode and clamping are on and hi_ready_i is low. It is high in every other case.
- R11: During reset, rd_data_o, acc_addend_o and rd_valid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 4*DATA_W | Raw stored result, word k at bits [16k+15:16k] |
| carry_i | input | 1 | Carry bit of the accumulator |
| op_wide_i | input | 1 | 0: 16x16 operation, 1: any wider operation |
| sat_en_i | input | 1 | Clamping enable |
| frac_en_i | input | 1 | Fractional format enable |
| hi_ready_i | input | 1 | Highest result word has been computed |
| rd_data_o | output | 4*DATA_W | Read-back words, same slicing as res_i |
| acc_addend_o | output | 4*DATA_W | Integer-clamped value for the next accumulation |
| rd_valid_o | output | 1 | Read value is valid |

## Verification
The read value and the accumulation addend come from the same raw result in the same cycle, under different rules. With fractional format and clamping both on, a raw value whose top two bits differ but which has no integer overflow makes the read clamp while the addend passes through unshifted. The sweep drives every combination of clamping, fractional format, carry and width across many raw values on a narrow build. On each vector it compares both outputs, and the valid flag, against an arithmetic model. Directed vectors on the full-width build cover the -1.0 x -1.0 case and the worked accumulation example.

// File: rtl/fsat_pkg.sv
package fsat_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_POS  = 2'd1,
    SAT_NEG  = 2'd2
  } sat_kind_e;
endpackage

// File: rtl/fsat_judge.sv
module fsat_judge
  import fsat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         carry_i,
  input  logic         sat_en_i,
  input  logic         frac_en_i,
  output sat_kind_e    int_kind_o,
  output sat_kind_e    rd_kind_o
);
  logic msb, nxt;
  assign msb = val_i[W-1];
  assign nxt = val_i[W-2];

  always_comb begin
    int_kind_o = SAT_NONE;
    if (sat_en_i) begin
      if (msb && !carry_i)      int_kind_o = SAT_POS;
      else if (!msb && carry_i) int_kind_o = SAT_NEG;
    end
  end

  // fractional read: shifted value would lose the sign
  always_comb begin
    rd_kind_o = int_kind_o;
    if (int_kind_o == SAT_NONE && sat_en_i && frac_en_i && (msb ^ nxt))
      rd_kind_o = msb ? SAT_NEG : SAT_POS;
  end
endmodule

// File: rtl/fsat_apply.sv
module fsat_apply
  import fsat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  sat_kind_e    kind_i,
  input  logic         shift_i,
  output logic [W-1:0] val_o
);
  always_comb begin
    unique case (kind_i)
      SAT_POS: val_o = {1'b0, {(W-1){1'b1}}};
      SAT_NEG: val_o = {1'b1, {(W-1){1'b0}}};
      default: val_o = shift_i ? {val_i[W-2:0], 1'b0} : val_i;
    endcase
  end
endmodule

// File: rtl/fsat_read_path.sv
module fsat_read_path
  import fsat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4*DATA_W-1:0] res_i,
  input  logic                carry_i,
  input  logic                op_wide_i,
  input  logic                sat_en_i,
  input  logic                frac_en_i,
  input  logic                hi_ready_i,
  output logic [4*DATA_W-1:0] rd_data_o,
  output logic [4*DATA_W-1:0] acc_addend_o,
  output logic                rd_valid_o
);
  localparam int RES_W    = 4 * DATA_W;
  localparam int NARROW_W = 2 * DATA_W;
  localparam int N_SIZES  = 2;

  logic [RES_W-1:0] rd_cand  [N_SIZES];
  logic [RES_W-1:0] acc_cand [N_SIZES];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int GW = (g == 0) ? NARROW_W : RES_W;
    sat_kind_e        int_kind, rd_kind;
    logic [GW-1:0]    rd_w, acc_w;

    fsat_judge #(.W(GW)) i_judge (
      .val_i      (res_i[GW-1:0]),
      .carry_i    (carry_i),
      .sat_en_i   (sat_en_i),
      .frac_en_i  (frac_en_i),
      .int_kind_o (int_kind),
      .rd_kind_o  (rd_kind)
    );

    fsat_apply #(.W(GW)) i_apply_rd (
      .val_i   (res_i[GW-1:0]),
      .kind_i  (rd_kind),
      .shift_i (frac_en_i),
      .val_o   (rd_w)
    );

    // addend never shifted, integer rules only
    fsat_apply #(.W(GW)) i_apply_acc (
      .val_i   (res_i[GW-1:0]),
      .kind_i  (int_kind),
      .shift_i (1'b0),
      .val_o   (acc_w)
    );

    if (GW < RES_W) begin : g_part
      assign rd_cand[g]  = {res_i[RES_W-1:GW], rd_w};
      assign acc_cand[g] = {res_i[RES_W-1:GW], acc_w};
    end else begin : g_full
      assign rd_cand[g]  = rd_w;
      assign acc_cand[g] = acc_w;
    end
  end

  logic [RES_W-1:0] rd_d, acc_d;
  logic             valid_d;

  assign rd_d    = op_wide_i ? rd_cand[1]  : rd_cand[0];
  assign acc_d   = op_wide_i ? acc_cand[1] : acc_cand[0];
  assign valid_d = !(op_wide_i && sat_en_i) || hi_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o    <= '0;
      acc_addend_o <= '0;
      rd_valid_o   <= 1'b0;
    end else begin
      rd_data_o    <= rd_d;
      acc_addend_o <= acc_d;
      rd_valid_o   <= valid_d;
    end
  end

  assert_raw_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_en_i && !frac_en_i) |=> rd_data_o == $past(res_i));

  assert_pos_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_en_i && !op_wide_i && res_i[NARROW_W-1] && !carry_i)
    |=> rd_data_o[NARROW_W-1:0] == {1'b0, {(NARROW_W-1){1'b1}}});

  assert_neg_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_en_i && !op_wide_i && !res_i[NARROW_W-1] && carry_i)
    |=> rd_data_o[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}});

  assert_upper_raw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_wide_i |=> rd_data_o[RES_W-1:NARROW_W] == $past(res_i[RES_W-1:NARROW_W]));

  assert_wide_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_en_i && op_wide_i && res_i[RES_W-1] && !carry_i)
    |=> rd_data_o == {1'b0, {(RES_W-1){1'b1}}});

  assert_frac_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_en_i && !sat_en_i && !op_wide_i)
    |=> rd_data_o[NARROW_W-1:0] == {$past(res_i[NARROW_W-2:0]), 1'b0});

  assert_addend_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_en_i |=> acc_addend_o == $past(res_i));

  assert_valid_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_wide_i && sat_en_i && !hi_ready_i) |=> !rd_valid_o);
endmodule

// File: tb/test_fsat_read_path.sv
module test_fsat_read_path;
  localparam int SDW = 4;
  localparam int SW  = 4 * SDW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [SW-1:0] s_res;
  logic s_c, s_w, s_s, s_f, s_h;
  logic [SW-1:0] s_rd, s_acc;
  logic s_v;

  logic [63:0] f_res;
  logic f_c, f_w, f_s, f_f, f_h;
  logic [63:0] f_rd, f_acc;
  logic f_v;

  fsat_read_path #(.DATA_W(SDW)) i_fsat_read_path (
    .clk_i(clk), .rst_ni(rst_n), .res_i(s_res), .carry_i(s_c),
    .op_wide_i(s_w), .sat_en_i(s_s), .frac_en_i(s_f), .hi_ready_i(s_h),
    .rd_data_o(s_rd), .acc_addend_o(s_acc), .rd_valid_o(s_v));

  fsat_read_path #(.DATA_W(16)) i_fsat_read_path_w16 (
    .clk_i(clk), .rst_ni(rst_n), .res_i(f_res), .carry_i(f_c),
    .op_wide_i(f_w), .sat_en_i(f_s), .frac_en_i(f_f), .hi_ready_i(f_h),
    .rd_data_o(f_rd), .acc_addend_o(f_acc), .rd_valid_o(f_v));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fmask(int n);
    return (n >= 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] model(logic [63:0] raw, bit c, bit s, bit f,
                                        int n, bit rd);
    logic [63:0] m, maxp, minn, act, o;
    bit msb, nb;
    m = fmask(n);
    maxp = m >> 1;
    minn = maxp + 64'd1;
    act = raw & m;
    msb = raw[n-1];
    nb  = raw[n-2];
    if (s && msb && !c)                  o = maxp;
    else if (s && !msb && c)             o = minn;
    else if (rd && f && s && (msb != nb)) o = msb ? minn : maxp;
    else if (rd && f)                    o = (act << 1) & m;
    else                                 o = act;
    return (raw & ~m) | o;
  endfunction

  function automatic string rd_tag(logic [63:0] raw, bit c, bit s, bit f, bit w, int n);
    bit msb, nb;
    msb = raw[n-1];
    nb  = raw[n-2];
    if (w && s && (msb != c))             return "R5";
    if (!w && s && msb && !c)             return "R2";
    if (!w && s && !msb && c)             return "R3";
    if (f && s && (msb != nb))            return "R7";
    if (f)                                return "R6";
    return "R1";
  endfunction

  task automatic run_small(logic [SW-1:0] v, bit c, bit w, bit s, bit f, bit h);
    int n;
    logic [63:0] raw;
    n = w ? SW : 2 * SDW;
    raw = {{(64-SW){1'b0}}, v};
    s_res = v; s_c = c; s_w = w; s_s = s; s_f = f; s_h = h;
    @(posedge clk);
    @(negedge clk);
    chk(rd_tag(raw, c, s, f, w, n), {{(64-SW){1'b0}}, s_rd},
        model(raw, c, s, f, n, 1'b1) & fmask(SW));
    if (!w)
      chk("R4", {{(64-SW){1'b0}}, s_rd[SW-1:2*SDW]}, raw >> (2 * SDW));
    chk("R8", {{(64-SW){1'b0}}, s_acc}, model(raw, c, s, f, n, 1'b0) & fmask(SW));
    chk("R10", {63'd0, s_v}, {63'd0, (!(w && s)) || h});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    s_res = '1; s_c = 1; s_w = 1; s_s = 1; s_f = 1; s_h = 1;
    f_res = '1; f_c = 1; f_w = 1; f_s = 1; f_f = 1; f_h = 1;
    repeat (3) @(negedge clk);
    chk("R11", {{(64-SW){1'b0}}, s_rd}, 64'd0);
    chk("R11", {{(64-SW){1'b0}}, s_acc}, 64'd0);
    chk("R11", {63'd0, s_v}, 64'd0);
    chk("R11", f_rd, 64'd0);
    chk("R11", {63'd0, f_v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 65536; v += (w != 0) ? 11 : 13)
            run_small(v[SW-1:0], c[0], w[0], m[0], m[1], v[1]);

    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            case (k)
              0: b = 8'h80; 1: b = 8'h7F; 2: b = 8'h40; 3: b = 8'hBF;
              4: b = 8'hC0; 5: b = 8'h3F; 6: b = 8'h00; default: b = 8'hFF;
            endcase
            if (w != 0) run_small({b, 8'h5A}, c[0], 1'b1, m[0], m[1], k[0]);
            else        run_small({8'hA5, b}, c[0], 1'b0, m[0], m[1], k[0]);
          end

    // full-width directed vectors
    f_res = 64'h0000_0000_8000_059F; f_c = 0; f_w = 0; f_s = 1; f_f = 1; f_h = 0;
    @(posedge clk); @(negedge clk);
    chk("R9", {48'd0, f_rd[15:0]}, 64'h0000_0000_0000_FFFF);
    chk("R9", {48'd0, f_rd[31:16]}, 64'h0000_0000_0000_7FFF);
    chk("R8", f_acc, 64'h0000_0000_7FFF_FFFF);

    f_res = 64'h0000_0000_4000_0000; f_c = 0;
    @(posedge clk); @(negedge clk);
    chk("R7", f_rd, 64'h0000_0000_7FFF_FFFF);
    chk("R8", f_acc, 64'h0000_0000_4000_0000);

    f_res = 64'h7000_0000_0000_0001; f_c = 1; f_w = 1; f_s = 1; f_f = 0; f_h = 0;
    @(posedge clk); @(negedge clk);
    chk("R5", f_rd, 64'h8000_0000_0000_0000);
    chk("R10", {63'd0, f_v}, 64'd0);
    f_h = 1;
    @(posedge clk); @(negedge clk);
    chk("R10", {63'd0, f_v}, 64'd1);

    f_res = 64'h1234_5678_9ABC_DEF0; f_c = 0; f_w = 0; f_s = 0; f_f = 0;
    @(posedge clk); @(negedge clk);
    chk("R1", f_rd, 64'h1234_5678_9ABC_DEF0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule